// File: doc/BRIEF.md
# Synapse row update engine

The engine takes one synapse row per presynaptic event and makes a single read-modify-write pass over it. A row is a stream of 32-bit words. The first word is the row's stored presynaptic time stamp. Each later word is one connection to a local target neuron. A row-start strobe announces the row and carries two values: the number of connection words and the refreshed time stamp that replaces the stored one. The same strobe arms the engine.

For every connection word the engine decodes the target index and the delay. It presents the target index and the stored stamp to a post-synaptic stamp store. The store answers in the same cycle with an enable and a signed weight change, and the engine applies that change with clamping. The engine then sends the target, the delay and the adjusted weight to the input accumulator. It also emits the rewritten word for write-back. Write-back words leave in input order, with the refreshed stamp first. All three streams use valid/ready handshakes. A one-cycle done pulse follows once the last word of the row has left.

Word layout: the weight is in bits 31:16, the delay in bits 15:12 and a reserved bit in bit 11, which passes through untouched. The target index is in bits 10:0.

Top module: `syn_row_engine`

## Requirements
- R1: After reset, in_ready, wb_valid, stim_valid and row_done are all 0, and in_ready stays 0 until a row_start is taken.
- R2: The first write-back word of every row is the row_stamp value captured with row_start. The incoming header word produces no stimulus.
- R3: For every entry word, stim_target is bits 10:0 and stim_delay is bits 15:12 of that word, and stim_weight is the adjusted weight.
- R4: When q_apply is 0, the write-back word equals the incoming entry word bit for bit.
- R5: When q_apply is 1, the new weight is old weight plus the signed q_delta, clamped to 0..65535. Bits 15:0, including reserved bit 11, are unchanged.
- R6: While an entry word is offered, q_target equals its bits 10:0 and q_stamp equals the header word of the current row.
- R7: A row of N entries gives exactly N+1 write-back words and N stimuli, each in input order.
- R8: While an output is valid and not ready, it holds its data. Backpressure on either output stalls the input, and no word is lost or duplicated.
- R9: row_done is high for exactly one cycle, once both outputs have emptied after the row's last word. A row with zero entries yields only the stamp word and then row_done.
- R10: A row_start strobe while a row is in progress is ignored, and its length and stamp have no effect on that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_start | input | 1 | Starts a row when the engine is idle |
| row_len | input | 11 | Entry count of the row, taken with row_start |
| row_stamp | input | 32 | Refreshed time stamp to write back, taken with row_start |
| in_valid | input | 1 | Row word valid |
| in_ready | output | 1 | Engine accepts the row word |
| in_data | input | 32 | Row word |
| q_target | output | 11 | Target index presented to the stamp store |
| q_stamp | output | 32 | Stored presynaptic stamp presented to the stamp store |
| q_apply | input | 1 | Stamp store: adjust this weight |
| q_delta | input | 16 | Stamp store: signed weight change |
| stim_valid | output | 1 | Stimulus valid |
| stim_ready | input | 1 | Accumulator accepts the stimulus |
| stim_target | output | 11 | Stimulus target neuron |
| stim_delay | output | 4 | Stimulus delay |
| stim_weight | output | 16 | Stimulus weight (adjusted) |
| wb_valid | output | 1 | Write-back word valid |
| wb_ready | input | 1 | Write-back sink accepts the word |
| wb_data | output | 32 | Write-back word |
| row_done | output | 1 | One-cycle pulse at the end of a row |

## Verification
A bad entry counter shows up as a write-back stream one word too long or too short. A row_done pulse that comes early or late, or a stream that hangs, shows the same fault, and each of these appears within one row. A wrong stored stamp shows on q_stamp in the first entry cycle, before any output leaves. A corrupted output slot under backpressure shows as a changed or doubled word on the stalled port in the cycle after the stall begins. The scoreboard compares every word in order and catches each of these faults at the next word popped.

// File: rtl/syn_row_pkg.sv
package syn_row_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HDR   = 2'd1,
      ST_ENT   = 2'd2,
      ST_DRAIN = 2'd3
   } row_state_e;

endpackage

// File: rtl/syn_hold_slot.sv
module syn_hold_slot #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         take,
   output logic         valid,
   output logic [W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (take) begin
         valid <= 1'b0;
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !take && !load) |=> (valid && $stable(dout)));

endmodule

// File: rtl/syn_entry_adjust.sv
module syn_entry_adjust #(
   parameter int WORD_W   = 32,
   parameter int WEIGHT_W = 16,
   parameter int DLY_W    = 4,
   parameter int TGT_W    = 11,
   parameter bit SATURATE = 1'b1
) (
   input  logic [WORD_W-1:0]   word,
   input  logic                apply,
   input  logic [WEIGHT_W-1:0] delta,
   output logic [TGT_W-1:0]    target,
   output logic [DLY_W-1:0]    delay,
   output logic [WEIGHT_W-1:0] old_weight,
   output logic [WEIGHT_W-1:0] new_weight,
   output logic [WORD_W-1:0]   new_word
);

   localparam int PARAM_W = WORD_W - WEIGHT_W;
   localparam int RSV_W   = PARAM_W - DLY_W - TGT_W;
   localparam int SUM_W   = WEIGHT_W + 2;

   logic signed [SUM_W-1:0] sum;
   logic [WEIGHT_W-1:0]     adjusted;

   assign target     = word[TGT_W-1:0];
   assign delay      = word[TGT_W+RSV_W +: DLY_W];
   assign old_weight = word[WORD_W-1 -: WEIGHT_W];

   assign sum = $signed({2'b00, old_weight}) +
                $signed({{2{delta[WEIGHT_W-1]}}, delta});

   generate
      if (SATURATE) begin : g_clamp
         always_comb begin
            if (sum < 0)
               adjusted = '0;
            else if (sum[SUM_W-2])
               adjusted = '1;
            else
               adjusted = sum[WEIGHT_W-1:0];
         end
      end else begin : g_wrap
         assign adjusted = sum[WEIGHT_W-1:0];
      end
   endgenerate

   assign new_weight = apply ? adjusted : old_weight;
   assign new_word   = {new_weight, word[PARAM_W-1:0]};

endmodule

// File: rtl/syn_row_engine.sv
module syn_row_engine
   import syn_row_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int WEIGHT_W = 16,
   parameter int DLY_W    = 4,
   parameter int TGT_W    = 11,
   parameter int CNT_W    = 11,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                row_start,
   input  logic [CNT_W-1:0]    row_len,
   input  logic [WORD_W-1:0]   row_stamp,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WORD_W-1:0]   in_data,
   output logic [TGT_W-1:0]    q_target,
   output logic [WORD_W-1:0]   q_stamp,
   input  logic                q_apply,
   input  logic [WEIGHT_W-1:0] q_delta,
   output logic                stim_valid,
   input  logic                stim_ready,
   output logic [TGT_W-1:0]    stim_target,
   output logic [DLY_W-1:0]    stim_delay,
   output logic [WEIGHT_W-1:0] stim_weight,
   output logic                wb_valid,
   input  logic                wb_ready,
   output logic [WORD_W-1:0]   wb_data,
   output logic                row_done
);

   localparam int RSV_W  = WORD_W - WEIGHT_W - DLY_W - TGT_W;
   localparam int STIM_W = TGT_W + DLY_W + WEIGHT_W;

   generate
      if (RSV_W < 1) begin : g_bad_layout
         $error("syn_row_engine: fields leave no reserved bit");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("syn_row_engine: CNT_W must be positive");
      end
   endgenerate

   row_state_e          state_q;
   logic [CNT_W-1:0]    rem_q;
   logic [WORD_W-1:0]   new_stamp_q;
   logic [WORD_W-1:0]   old_stamp_q;

   logic                can_load, acc, hdr_acc, ent_acc;
   logic [TGT_W-1:0]    adj_target;
   logic [DLY_W-1:0]    adj_delay;
   logic [WEIGHT_W-1:0] adj_old_w, adj_new_w;
   logic [WORD_W-1:0]   adj_word;
   logic [WORD_W-1:0]   wb_din;
   logic [STIM_W-1:0]   stim_din, stim_dout;

   assign can_load = (!wb_valid || wb_ready) && (!stim_valid || stim_ready);
   assign in_ready = ((state_q == ST_HDR) || (state_q == ST_ENT)) && can_load;
   assign acc      = in_valid && in_ready;
   assign hdr_acc  = acc && (state_q == ST_HDR);
   assign ent_acc  = acc && (state_q == ST_ENT);

   syn_entry_adjust #(
      .WORD_W  (WORD_W),
      .WEIGHT_W(WEIGHT_W),
      .DLY_W   (DLY_W),
      .TGT_W   (TGT_W),
      .SATURATE(SATURATE)
   ) u_adjust (
      .word      (in_data),
      .apply     (q_apply),
      .delta     (q_delta),
      .target    (adj_target),
      .delay     (adj_delay),
      .old_weight(adj_old_w),
      .new_weight(adj_new_w),
      .new_word  (adj_word)
   );

   assign q_target = adj_target;
   assign q_stamp  = old_stamp_q;
   assign wb_din   = hdr_acc ? new_stamp_q : adj_word;
   assign stim_din = {adj_target, adj_delay, adj_new_w};

   syn_hold_slot #(.W(WORD_W)) u_wb_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .load (acc),
      .din  (wb_din),
      .take (wb_ready),
      .valid(wb_valid),
      .dout (wb_data)
   );

   syn_hold_slot #(.W(STIM_W)) u_stim_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ent_acc),
      .din  (stim_din),
      .take (stim_ready),
      .valid(stim_valid),
      .dout (stim_dout)
   );

   assign stim_target = stim_dout[STIM_W-1 -: TGT_W];
   assign stim_delay  = stim_dout[WEIGHT_W +: DLY_W];
   assign stim_weight = stim_dout[WEIGHT_W-1:0];

   assign row_done = (state_q == ST_DRAIN) && !wb_valid && !stim_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         rem_q       <= '0;
         new_stamp_q <= '0;
         old_stamp_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (row_start) begin
               state_q     <= ST_HDR;
               rem_q       <= row_len;
               new_stamp_q <= row_stamp;
            end
            ST_HDR: if (hdr_acc) begin
               old_stamp_q <= in_data;
               state_q     <= (rem_q == '0) ? ST_DRAIN : ST_ENT;
            end
            ST_ENT: if (ent_acc) begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == CNT_W'(1))
                  state_q <= ST_DRAIN;
            end
            ST_DRAIN: if (row_done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   hdr_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_acc |=> (wb_valid && wb_data == $past(new_stamp_q) && !stim_valid));

   // R3
   ent_stim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_acc |=> (stim_valid && stim_target == $past(in_data[TGT_W-1:0])));

   // R4
   keep_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_acc && !q_apply) |=> (wb_data == $past(in_data)));

   // R5
   raise_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_acc && q_apply && !q_delta[WEIGHT_W-1] && SATURATE) |-> (adj_new_w >= adj_old_w));

   // R9
   done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |-> (!wb_valid && !stim_valid && !in_ready));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |=> !row_done);

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_start && state_q == ST_ENT && !ent_acc) |=> $stable(rem_q));

endmodule

// File: tb/syn_row_engine_test.sv
module syn_row_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        row_start = 1'b0;
   logic [10:0] row_len = '0;
   logic [31:0] row_stamp = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic [10:0] q_target;
   logic [31:0] q_stamp;
   logic        q_apply;
   logic [15:0] q_delta;
   logic        stim_valid;
   logic        stim_ready = 1'b1;
   logic [10:0] stim_target;
   logic [3:0]  stim_delay;
   logic [15:0] stim_weight;
   logic        wb_valid;
   logic        wb_ready = 1'b1;
   logic [31:0] wb_data;
   logic        row_done;

   int checks = 0;
   int fails  = 0;
   int done_cnt = 0;
   bit wb_stall = 0;
   bit stim_stall = 0;
   bit prev_done = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [31:0] wb_q[$];
   logic [30:0] stim_q[$];

   always #5 clk = ~clk;

   syn_row_engine uut (
      .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_len(row_len),
      .row_stamp(row_stamp), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .q_target(q_target), .q_stamp(q_stamp),
      .q_apply(q_apply), .q_delta(q_delta), .stim_valid(stim_valid),
      .stim_ready(stim_ready), .stim_target(stim_target),
      .stim_delay(stim_delay), .stim_weight(stim_weight),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
      .row_done(row_done)
   );

   // post-synaptic stamp store model: apply on odd targets
   function automatic logic [15:0] store_delta(input logic [10:0] t);
      case (t[2:1])
         2'd0:    return 16'd100;
         2'd1:    return -16'sd100;
         2'd2:    return 16'h7FFF;
         default: return 16'h8000;
      endcase
   endfunction

   always_comb begin
      q_apply = q_target[0];
      q_delta = store_delta(q_target);
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model_weight(input logic [31:0] w);
      int s;
      if (!w[0]) return w[31:16];
      s = int'(w[31:16]) + int'($signed(store_delta(w[10:0])));
      if (s < 0) return 16'h0000;
      if (s > 65535) return 16'hFFFF;
      return 16'(s);
   endfunction

   // stall generators
   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      wb_ready   = wb_stall   ? lfsr[3] : 1'b1;
      stim_ready = stim_stall ? lfsr[7] : 1'b1;
   end

   // monitor / scoreboard
   logic [31:0] stall_wb;
   bit          stall_wb_v = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_wb_v && wb_valid) begin
            // R8: held data while stalled
            check(wb_data == stall_wb, "R8 wb hold", wb_data, stall_wb);
         end
         stall_wb_v = wb_valid && !wb_ready;
         stall_wb   = wb_data;
         if (wb_valid && wb_ready) begin
            if (wb_q.size() == 0)
               check(0, "R7 extra wb word", wb_data, 32'h0);
            else begin
               logic [31:0] e;
               e = wb_q.pop_front();
               check(wb_data == e, "R2/R4/R5/R7 wb word", wb_data, e);
            end
         end
         if (stim_valid && stim_ready) begin
            if (stim_q.size() == 0)
               check(0, "R7 extra stim", {1'b0, stim_target, stim_delay, stim_weight}, 32'h0);
            else begin
               logic [30:0] e;
               e = stim_q.pop_front();
               check({stim_target, stim_delay, stim_weight} == e, "R3 stim fields",
                     {1'b0, stim_target, stim_delay, stim_weight}, {1'b0, e});
            end
         end
         if (row_done) begin
            check(wb_q.size() == 0 && stim_q.size() == 0 && !prev_done,
                  "R9 done timing", 32'(wb_q.size() + stim_q.size()), 32'h0);
            done_cnt++;
         end
         prev_done = row_done;
      end
   end

   task automatic send_word(input logic [31:0] w, input bit is_entry,
                            input logic [31:0] hdr);
      in_valid = 1'b1;
      in_data  = w;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      if (is_entry) begin
         // R6
         check(q_target == w[10:0] && q_stamp == hdr, "R6 query",
               {q_target, 21'h0} ^ q_stamp, {w[10:0], 21'h0} ^ hdr);
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic run_row(input int n, input int seed, input bit inject);
      logic [31:0] hdr, stamp;
      int target_done;
      hdr   = 32'hA000_0000 + 32'(seed * 17);
      stamp = 32'hB000_0000 + 32'(seed * 23);
      target_done = done_cnt + 1;
      @(posedge clk); #1;
      row_start = 1'b1;
      row_len   = 11'(n);
      row_stamp = stamp;
      @(posedge clk); #1;
      row_start = 1'b0;
      wb_q.push_back(stamp);
      send_word(hdr, 0, hdr);
      if (inject) begin
         // R10: foreign strobe mid-row
         row_start = 1'b1;
         row_len   = 11'd1;
         row_stamp = 32'hDEAD_BEEF;
         @(posedge clk); #1;
         row_start = 1'b0;
      end
      for (int i = 0; i < n; i++) begin
         logic [31:0] w;
         logic [15:0] wt;
         logic [10:0] tg;
         tg = 11'((i * 37 + seed * 5) & 32'h7FF);
         if (seed == 3) wt = i[0] ? 16'hFFF0 : 16'h0010;
         else wt = 16'((i * 7919 + seed * 31) & 32'hFFFF);
         w = {wt, 4'(i), (i % 3 == 0), tg};
         wb_q.push_back({model_weight(w), w[15:0]});
         stim_q.push_back({tg, 4'(i), model_weight(w)});
         send_word(w, 1, hdr);
      end
      while (done_cnt < target_done) @(negedge clk);
      @(negedge clk);
      check(!in_ready && !row_done, "R10/R9 idle after row",
            {30'h0, in_ready, row_done}, 32'h0);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      check(!in_ready && !wb_valid && !stim_valid && !row_done, "R1 reset",
            {28'h0, in_ready, wb_valid, stim_valid, row_done}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!in_ready, "R1 idle ready", {31'h0, in_ready}, 32'h0);

      run_row(4, 1, 0);
      run_row(0, 2, 0);
      wb_stall = 1;
      run_row(8, 3, 0);
      wb_stall = 0; stim_stall = 1;
      run_row(6, 4, 1);
      wb_stall = 1;
      run_row(20, 5, 0);
      wb_stall = 0; stim_stall = 0;
      run_row(1, 6, 1);
      check(done_cnt == 6, "R7/R9 row count", 32'(done_cnt), 32'd6);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule